// File: doc/BRIEF.md
# Nested Command Stream Router

This block sits between one upstream byte port (towards the host) and four downstream link ports. It reads a stream of tagged command bytes from upstream. Each byte carries a 2-bit tag in bits 7..6 and a 6-bit data field in bits 5..0. The data field is merged into a 32-bit operand word, and the tag says what to do with that word. Commands select the current link, forward length-prefixed payload packets to that link, pass whole bracketed sub-sequences through without interpreting them, trigger a peek of the node on the current link, and read back a window of local memory. After a forwarded sub-sequence the block relays the replies from the current link back upstream. A reply is a series of length-prefixed packets that ends with a zero length byte.

All ports use a valid/ready handshake, and a byte moves on a rising edge where both are high. Local memory is read through a synchronous port with one cycle of latency. The peek itself is carried out by an external engine. This block only raises a one-cycle trigger together with the link index and the word size.

The controller has ten states:
- `S_CMD`: decode the next command byte.
- `S_FWD`: send the held message command byte downstream.
- `S_PAY`: pass payload bytes through.
- `S_OPEN`: bracketed pass-through with a depth count.
- `S_RLEN`: relay a reply length byte.
- `S_RDAT`: relay reply data bytes.
- `S_DLEN`: emit a dump packet length.
- `S_DRD`: issue a memory read.
- `S_DWT`: capture the read data.
- `S_DSND`: emit the dump byte.

The transitions are:
- `S_CMD` goes to `S_FWD` on a MESSAGE.
- `S_CMD` goes to `S_OPEN` on OPEN.
- `S_CMD` goes to `S_DLEN` on the second number after ADDRESS.
- `S_FWD` goes to `S_PAY` for a nonzero length, or to `S_RLEN` for zero.
- `S_PAY` returns to `S_CMD` after the last payload byte.
- `S_OPEN` goes to `S_RLEN` on the matching CLOSE.
- `S_RLEN` goes to `S_RDAT` on a nonzero length, or to `S_CMD` on zero.
- `S_RDAT` returns to `S_RLEN` after the last byte.
- `S_DLEN` goes to `S_DRD`, or to `S_CMD` on a zero length.
- `S_DRD`, `S_DWT` and `S_DSND` then cycle once per byte, back to `S_DLEN` after the last byte of a packet.

Top module: `nested_cmd_router`

## Requirements
- R1: Tag encoding is 0 = MESSAGE, 1 = NUMBER, 2 = FUNCTION, 3 = PREFIX. A command acts on the operand value (operand OR data). PREFIX stores that value shifted left by 6 bits, and every other tag clears the operand after it acts.
- R2: A MESSAGE of length N > 0 forwards its own command byte and then the next N upstream bytes, unchanged and in order, to the current link only.
- R3: A MESSAGE of length 0 forwards the byte 0x00 to the current link and then enters reply relay.
- R4: A NUMBER sets the current link to the low 2 bits of its value. The current link is 0 after reset.
- R5: FUNCTION 5 (OPEN, byte 0x85) is not forwarded. All later bytes go to the current link until the matching FUNCTION 6 (CLOSE, byte 0x86). Inner OPEN/CLOSE commands, including prefixed ones whose operand value is 5 or 6, raise and lower the depth. The matching CLOSE is consumed without being forwarded, and reply relay follows.
- R6: FUNCTION 7 (ADDRESS, byte 0x87) makes the next two NUMBER commands a byte offset from address 0 and a byte count. Both may be prefix-extended. The link is not changed by these two numbers.
- R7: A dump sends upstream packets of min(60, remaining) bytes, each preceded by its length byte, read from consecutive addresses. It ends with a 0x00 byte. A count of 0 gives only 0x00.
- R8: FUNCTION 2 or 4 raises `peek_go` for one cycle with `peek_bytes` equal to 2 or 4 and `peek_link` equal to the current link. Nothing is sent on any port.
- R9: In reply relay, each length byte L read from the current link goes upstream, followed by L data bytes. Relay stops after a length byte of 0, which is itself forwarded.
- R10: FUNCTION values other than 2, 4, 5, 6 and 7 are ignored. They produce no output, and the current link and the mode are unchanged.
- R11: At most one downstream link has its valid or ready asserted at any time, and it is always the current link.
- R12: After reset the block accepts a command byte and asserts no output valid and no peek trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_in_valid | input | 1 | Upstream command byte valid |
| up_in_data | input | 8 | Upstream command byte |
| up_in_ready | output | 1 | Upstream command byte accepted |
| up_out_valid | output | 1 | Reply byte to upstream valid |
| up_out_data | output | 8 | Reply byte to upstream |
| up_out_ready | input | 1 | Upstream takes reply byte |
| dn_out_valid | output | NLINK | Per-link outgoing byte valid |
| dn_out_data | output | 8 | Outgoing byte, shared by all links |
| dn_out_ready | input | NLINK | Per-link outgoing byte ready |
| dn_in_valid | input | NLINK | Per-link reply byte valid |
| dn_in_data | input | 8*NLINK | Reply bytes, link i in bits 8i+7..8i |
| dn_in_ready | output | NLINK | Per-link reply byte ready |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| peek_go | output | 1 | One-cycle peek trigger |
| peek_link | output | 2 | Link to be peeked |
| peek_bytes | output | 3 | Word size of the peeked node in bytes |

## Verification
Directed streams cover:
- a message sent straight after reset, which exposes the link reset value;
- a zero-length message followed by a multi-packet reply, which separates correct relay termination from stopping early or running on;
- a nested bracket holding prefixed OPEN and CLOSE look-alikes, which separates depth tracking by operand value from raw byte matching;
- dumps with counts of 0, exactly 60 and 125, which expose off-by-one errors at packet edges.

Peeks and unknown functions are followed by a message whose exact destination shows whether the link or the mode was disturbed. Seeded random messages on random links with random lengths, and random prefix-encoded dumps, run under random ready back-pressure. They separate correct length counting and handshake stalls from data loss or duplication.

// File: rtl/router_pkg.sv
package router_pkg;

    typedef enum logic [1:0] {
        TAG_MSG = 2'd0,
        TAG_NUM = 2'd1,
        TAG_FUN = 2'd2,
        TAG_PFX = 2'd3
    } tag_e;

    typedef enum logic [3:0] {
        S_CMD, S_FWD, S_PAY, S_OPEN, S_RLEN,
        S_RDAT, S_DLEN, S_DRD, S_DWT, S_DSND
    } state_e;

    localparam int FN_PEEK2 = 2;
    localparam int FN_PEEK4 = 4;
    localparam int FN_OPEN  = 5;
    localparam int FN_CLOSE = 6;
    localparam int FN_ADDR  = 7;

endpackage

// File: rtl/opnd_accum.sv
module opnd_accum import router_pkg::*; #(
    parameter int OPND_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [7:0]        byte_in,
    output tag_e              tag,
    output logic [OPND_W-1:0] val
);

    logic [OPND_W-1:0] op_q;

    assign tag = tag_e'(byte_in[7:6]);
    assign val = op_q | OPND_W'(byte_in[5:0]);

    always_ff @(posedge clk) begin
        if (!rst_n)
            op_q <= '0;
        else if (take)
            op_q <= (tag == TAG_PFX) ? (val << 6) : '0;
    end

    // R1: a non-prefix byte leaves a clean operand for the next command
    a_r1_operand_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (take && tag != TAG_PFX) |=> (val == OPND_W'(byte_in[5:0])));

endmodule

// File: rtl/link_xbar.sv
module link_xbar #(
    parameter  int NLINK  = 4,
    localparam int LINK_W = $clog2(NLINK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINK_W-1:0] sel,
    input  logic              out_valid,
    output logic              out_ready,
    input  logic              in_ready,
    output logic              in_valid,
    output logic [7:0]        in_data,
    output logic [NLINK-1:0]  dn_out_valid,
    input  logic [NLINK-1:0]  dn_out_ready,
    input  logic [NLINK-1:0]  dn_in_valid,
    input  logic [NLINK*8-1:0] dn_in_data,
    output logic [NLINK-1:0]  dn_in_ready
);

    for (genvar i = 0; i < NLINK; i++) begin : g_lane
        assign dn_out_valid[i] = out_valid && (sel == LINK_W'(i));
        assign dn_in_ready[i]  = in_ready  && (sel == LINK_W'(i));
    end

    assign out_ready = dn_out_ready[sel];
    assign in_valid  = dn_in_valid[sel];
    assign in_data   = dn_in_data[sel*8 +: 8];

    // R11: only the selected lane ever sees valid or ready
    a_r11_out_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_out_valid));
    a_r11_in_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_in_ready));

endmodule

// File: rtl/nested_cmd_router.sv
module nested_cmd_router import router_pkg::*; #(
    parameter  int NLINK     = 4,
    parameter  int ADDR_W    = 10,
    parameter  int OPND_W    = 32,
    parameter  int PKT_MAX   = 60,
    parameter  int MAX_DEPTH = 15,
    localparam int LINK_W    = $clog2(NLINK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_in_valid,
    input  logic [7:0]         up_in_data,
    output logic               up_in_ready,
    output logic               up_out_valid,
    output logic [7:0]         up_out_data,
    input  logic               up_out_ready,
    output logic [NLINK-1:0]   dn_out_valid,
    output logic [7:0]         dn_out_data,
    input  logic [NLINK-1:0]   dn_out_ready,
    input  logic [NLINK-1:0]   dn_in_valid,
    input  logic [NLINK*8-1:0] dn_in_data,
    output logic [NLINK-1:0]   dn_in_ready,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic [7:0]         mem_rd_data,
    output logic               peek_go,
    output logic [LINK_W-1:0]  peek_link,
    output logic [2:0]         peek_bytes
);

    localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);

    state_e              state_q, state_d;
    logic [LINK_W-1:0]   link_q;
    logic [7:0]          remain_q, hold_q, byte_q, chunk;
    logic [DEPTH_W-1:0]  depth_q;
    logic [1:0]          aphase_q;
    logic [ADDR_W-1:0]   offset_q;
    logic [OPND_W-1:0]   count_q, op_val;
    tag_e                op_tag;
    logic                op_take, fin;
    logic                sel_out_valid, sel_out_ready;
    logic                sel_in_valid, sel_in_ready;
    logic [7:0]          sel_in_data;
    logic                in_fire, out_fire, up_fire;

    opnd_accum #(.OPND_W(OPND_W)) u_opnd (
        .clk(clk), .rst_n(rst_n), .take(op_take), .byte_in(up_in_data),
        .tag(op_tag), .val(op_val)
    );

    link_xbar #(.NLINK(NLINK)) u_xbar (
        .clk(clk), .rst_n(rst_n), .sel(link_q),
        .out_valid(sel_out_valid), .out_ready(sel_out_ready),
        .in_ready(sel_in_ready), .in_valid(sel_in_valid), .in_data(sel_in_data),
        .dn_out_valid(dn_out_valid), .dn_out_ready(dn_out_ready),
        .dn_in_valid(dn_in_valid), .dn_in_data(dn_in_data), .dn_in_ready(dn_in_ready)
    );

    assign chunk       = (count_q > OPND_W'(PKT_MAX)) ? 8'(PKT_MAX) : count_q[7:0];
    assign fin         = up_in_valid && (op_tag == TAG_FUN) &&
                         (op_val == OPND_W'(FN_CLOSE)) && (depth_q == DEPTH_W'(1));
    assign in_fire     = up_in_valid && up_in_ready;
    assign out_fire    = sel_out_valid && sel_out_ready;
    assign up_fire     = up_out_valid && up_out_ready;
    assign mem_rd_addr = offset_q;
    assign peek_link   = link_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_CMD;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        up_in_ready   = 1'b0;
        sel_out_valid = 1'b0;
        dn_out_data   = up_in_data;
        up_out_valid  = 1'b0;
        up_out_data   = sel_in_data;
        sel_in_ready  = 1'b0;
        mem_rd_en     = 1'b0;
        op_take       = 1'b0;
        unique case (state_q)
            S_CMD: begin
                up_in_ready = 1'b1;
                op_take     = up_in_valid;
            end
            S_FWD: begin
                sel_out_valid = 1'b1;
                dn_out_data   = hold_q;
            end
            S_PAY: begin
                sel_out_valid = up_in_valid;
                up_in_ready   = sel_out_ready;
            end
            S_OPEN: begin
                sel_out_valid = up_in_valid && !fin;
                up_in_ready   = fin || sel_out_ready;
                op_take       = up_in_valid && (fin || sel_out_ready);
            end
            S_RLEN, S_RDAT: begin
                up_out_valid = sel_in_valid;
                sel_in_ready = up_out_ready;
            end
            S_DLEN: begin
                up_out_valid = 1'b1;
                up_out_data  = chunk;
            end
            S_DRD:  mem_rd_en = 1'b1;
            S_DWT:  ;
            S_DSND: begin
                up_out_valid = 1'b1;
                up_out_data  = byte_q;
            end
            default: ;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_CMD: if (in_fire) begin
                unique case (op_tag)
                    TAG_MSG: state_d = S_FWD;
                    TAG_NUM: if (aphase_q == 2'd2) state_d = S_DLEN;
                    TAG_FUN: if (op_val == OPND_W'(FN_OPEN)) state_d = S_OPEN;
                    TAG_PFX: ;
                    default: ;
                endcase
            end
            S_FWD:  if (out_fire) state_d = (remain_q == 8'd0) ? S_RLEN : S_PAY;
            S_PAY:  if (out_fire && remain_q == 8'd1) state_d = S_CMD;
            S_OPEN: if (in_fire && fin) state_d = S_RLEN;
            S_RLEN: if (up_fire) state_d = (sel_in_data == 8'd0) ? S_CMD : S_RDAT;
            S_RDAT: if (up_fire && remain_q == 8'd1) state_d = S_RLEN;
            S_DLEN: if (up_fire) state_d = (chunk == 8'd0) ? S_CMD : S_DRD;
            S_DRD:  state_d = S_DWT;
            S_DWT:  state_d = S_DSND;
            S_DSND: if (up_fire) state_d = (remain_q == 8'd1) ? S_DLEN : S_DRD;
            default: state_d = S_CMD;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q     <= '0;
            remain_q   <= '0;
            hold_q     <= '0;
            byte_q     <= '0;
            depth_q    <= '0;
            aphase_q   <= '0;
            offset_q   <= '0;
            count_q    <= '0;
            peek_go    <= 1'b0;
            peek_bytes <= '0;
        end else begin
            peek_go <= 1'b0;
            unique case (state_q)
                S_CMD: if (in_fire) begin
                    unique case (op_tag)
                        TAG_MSG: begin
                            hold_q   <= up_in_data;
                            remain_q <= op_val[7:0];
                        end
                        TAG_NUM: begin
                            if (aphase_q == 2'd1) begin
                                offset_q <= op_val[ADDR_W-1:0];
                                aphase_q <= 2'd2;
                            end else if (aphase_q == 2'd2) begin
                                count_q  <= op_val;
                                aphase_q <= 2'd0;
                            end else begin
                                link_q <= op_val[LINK_W-1:0];
                            end
                        end
                        TAG_FUN: begin
                            if (op_val == OPND_W'(FN_PEEK2) || op_val == OPND_W'(FN_PEEK4)) begin
                                peek_go    <= 1'b1;
                                peek_bytes <= op_val[2:0];
                            end else if (op_val == OPND_W'(FN_OPEN)) begin
                                depth_q <= DEPTH_W'(1);
                            end else if (op_val == OPND_W'(FN_ADDR)) begin
                                aphase_q <= 2'd1;
                            end
                        end
                        TAG_PFX: ;
                        default: ;
                    endcase
                end
                S_PAY:  if (out_fire) remain_q <= remain_q - 8'd1;
                S_OPEN: if (in_fire && op_tag == TAG_FUN) begin
                    if (op_val == OPND_W'(FN_OPEN))
                        depth_q <= depth_q + DEPTH_W'(1);
                    else if (op_val == OPND_W'(FN_CLOSE))
                        depth_q <= depth_q - DEPTH_W'(1);
                end
                S_RLEN: if (up_fire) remain_q <= sel_in_data;
                S_RDAT: if (up_fire) remain_q <= remain_q - 8'd1;
                S_DLEN: if (up_fire) remain_q <= chunk;
                S_DWT:  byte_q <= mem_rd_data;
                S_DSND: if (up_fire) begin
                    offset_q <= offset_q + ADDR_W'(1);
                    count_q  <= count_q - OPND_W'(1);
                    remain_q <= remain_q - 8'd1;
                end
                default: ;
            endcase
        end
    end

    // R5: inside a bracket the depth never reaches zero
    a_r5_depth_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OPEN) |-> (depth_q != '0));
    // R7: a dump length byte never exceeds the packet limit
    a_r7_chunk_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DLEN && up_out_valid) |-> (up_out_data <= 8'(PKT_MAX)));
    // R7: a stalled dump byte holds its value
    a_r7_dump_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DSND && up_out_valid && !up_out_ready) |=> (up_out_valid && $stable(up_out_data)));
    // R8: the peek trigger always carries a legal word size
    a_r8_peek_size: assert property (@(posedge clk) disable iff (!rst_n)
        peek_go |-> (peek_bytes == 3'd2 || peek_bytes == 3'd4));
    // R2: the held command byte stays put until the link takes it
    a_r2_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FWD && !sel_out_ready) |=> ($stable(dn_out_data) && $stable(dn_out_valid)));

endmodule

// File: tb/sim_nested_cmd_router.sv
module sim_nested_cmd_router;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_in_valid = 1'b0, up_in_ready;
    logic [7:0]  up_in_data = '0;
    logic        up_out_valid, up_out_ready = 1'b0;
    logic [7:0]  up_out_data;
    logic [3:0]  dn_out_valid, dn_out_ready = '0;
    logic [7:0]  dn_out_data;
    logic [3:0]  dn_in_valid = '0, dn_in_ready;
    logic [31:0] dn_in_data = '0;
    logic        mem_rd_en;
    logic [9:0]  mem_rd_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        peek_go;
    logic [1:0]  peek_link;
    logic [2:0]  peek_bytes;

    int total = 0, bad = 0, cyc = 0, quiet = 0, src_link = 0;
    int host_q[$], src_q[$], obs_rx[$], obs_up[$], obs_pk[$], exp_q[$];

    nested_cmd_router u0 (
        .clk(clk), .rst_n(rst_n),
        .up_in_valid(up_in_valid), .up_in_data(up_in_data), .up_in_ready(up_in_ready),
        .up_out_valid(up_out_valid), .up_out_data(up_out_data), .up_out_ready(up_out_ready),
        .dn_out_valid(dn_out_valid), .dn_out_data(dn_out_data), .dn_out_ready(dn_out_ready),
        .dn_in_valid(dn_in_valid), .dn_in_data(dn_in_data), .dn_in_ready(dn_in_ready),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .peek_go(peek_go), .peek_link(peek_link), .peek_bytes(peek_bytes)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int memf(input int a);
        return ((a & 1023) * 37 + ((a & 1023) >> 4) + 11) & 255;
    endfunction

    always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= 8'(memf(int'(mem_rd_addr)));

    // stimulus drive and handshake observation, away from the active edge
    initial forever begin
        @(negedge clk);
        for (int i = 0; i < 4; i++) dn_out_ready[i] = ($urandom % 4) != 0;
        up_out_ready = ($urandom % 4) != 0;
        up_in_valid  = host_q.size() > 0;
        up_in_data   = host_q.size() > 0 ? 8'(host_q[0]) : 8'h00;
        dn_in_valid  = '0;
        dn_in_data   = '0;
        if (src_q.size() > 0) begin
            dn_in_valid[src_link] = 1'b1;
            dn_in_data[src_link*8 +: 8] = 8'(src_q[0]);
        end
        #(CLK_PERIOD/2 - 1);
        quiet++;
        if (up_in_valid && up_in_ready) begin void'(host_q.pop_front()); quiet = 0; end
        for (int i = 0; i < 4; i++)
            if (dn_out_valid[i] && dn_out_ready[i]) begin
                obs_rx.push_back(32'h100000 | (i << 8) | int'(dn_out_data)); quiet = 0;
            end
        if (dn_in_valid[src_link] && dn_in_ready[src_link]) void'(src_q.pop_front());
        if (up_out_valid && up_out_ready) begin obs_up.push_back(32'h200000 | int'(up_out_data)); quiet = 0; end
        if (peek_go) begin obs_pk.push_back(32'h300000 | (int'(peek_link) << 8) | int'(peek_bytes)); quiet = 0; end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            total++; bad++;
            $display("FAIL watchdog: actual cycles=%0d expected <= %0d", cyc, WDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic put(input int b); host_q.push_back(b & 255); endtask
    task automatic ex_rx(input int l, input int b); exp_q.push_back(32'h100000 | (l << 8) | (b & 255)); endtask
    task automatic ex_up(input int b); exp_q.push_back(32'h200000 | (b & 255)); endtask

    task automatic ex_dump(input int off, input int cnt);
        int n;
        do begin
            n = cnt > 60 ? 60 : cnt;
            ex_up(n);
            for (int i = 0; i < n; i++) ex_up(memf(off + i));
            off += n; cnt -= n;
        end while (n != 0);
    endtask

    // wait for all stimulus to drain, then compare observed against expected
    task automatic settle_cmp(input string rq);
        int obs[$];
        int idx;
        while (host_q.size() > 0 || src_q.size() > 0) @(negedge clk);
        quiet = 0;
        while (quiet < 40) @(negedge clk);
        foreach (obs_rx[i]) obs.push_back(obs_rx[i]);
        foreach (obs_up[i]) obs.push_back(obs_up[i]);
        foreach (obs_pk[i]) obs.push_back(obs_pk[i]);
        idx = -1;
        for (int i = 0; i < obs.size() && i < exp_q.size(); i++)
            if (idx < 0 && obs[i] != exp_q[i]) idx = i;
        if (idx < 0 && obs.size() != exp_q.size())
            check({rq, " event count"}, obs.size(), exp_q.size());
        else if (idx >= 0)
            check($sformatf("%s event %0d", rq, idx), obs[idx], exp_q[idx]);
        else
            check(rq, 0, 0);
        obs_rx.delete(); obs_up.delete(); obs_pk.delete(); exp_q.delete();
    endtask

    task automatic put_num(input int v);
        if (v >= 64) put(8'hC0 | ((v >> 6) & 63));
        put(8'h40 | (v & 63));
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R12: idle after reset
        check("R12 up_in_ready", up_in_ready, 1);
        check("R12 up_out_valid", up_out_valid, 0);
        check("R12 dn_out_valid", dn_out_valid, 0);
        check("R12 peek_go", peek_go, 0);

        // R4 reset link 0, R2 message forward
        put(8'h01); put(8'hA5); ex_rx(0, 8'h01); ex_rx(0, 8'hA5);
        settle_cmp("R4 R2 link0 message");

        // R4 number select, R2 three-byte packet
        put(8'h42); put(8'h03); put(8'h11); put(8'h22); put(8'h33);
        ex_rx(2, 3); ex_rx(2, 8'h11); ex_rx(2, 8'h22); ex_rx(2, 8'h33);
        settle_cmp("R4 R2 link2 message");

        // R3 zero message then R9 relay of two packets and terminator
        src_link = 2;
        src_q = '{2, 8'h9A, 8'h9B, 1, 8'h9C, 0};
        put(8'h00); ex_rx(2, 0);
        ex_up(2); ex_up(8'h9A); ex_up(8'h9B); ex_up(1); ex_up(8'h9C); ex_up(0);
        settle_cmp("R3 R9 relay");

        // R5 bracket with prefixed look-alikes, then relay
        put(8'h41); put(8'h85);
        put(8'h42); put(8'hC0); put(8'h85); put(8'hC1); put(8'h86); put(8'h86); put(8'h86);
        ex_rx(1, 8'h42); ex_rx(1, 8'hC0); ex_rx(1, 8'h85); ex_rx(1, 8'hC1); ex_rx(1, 8'h86); ex_rx(1, 8'h86);
        src_link = 1; src_q = '{1, 8'h55, 0};
        ex_up(1); ex_up(8'h55); ex_up(0);
        settle_cmp("R5 nested bracket");

        // R1 prefixed numbers, R6 address, R7 three packets
        put(8'h87); put(8'hC5); put(8'h50); put(8'hC1); put(8'h7D);
        ex_dump(336, 125);
        settle_cmp("R1 R6 R7 dump 125");

        // R7 zero count and exact 60
        put(8'h87); put(8'h40); put(8'h40); ex_dump(0, 0);
        settle_cmp("R7 dump count 0");
        put(8'h87); put(8'h41); put(8'h7C); ex_dump(1, 60);
        settle_cmp("R7 dump count 60");

        // R6 link unchanged by address numbers, R8 peeks
        put(8'h43); put(8'h87); put(8'h40); put(8'h41); ex_dump(0, 1);
        put(8'h82); put(8'h84);
        exp_q.push_back(32'h300302); exp_q.push_back(32'h300304);
        settle_cmp("R6 R8 peeks on link3");

        // R10 unknown functions ignored, link 3 still current
        put(8'h83); put(8'h80); put(8'hBF); put(8'h81); put(8'h01); put(8'h7E);
        ex_rx(3, 1); ex_rx(3, 8'h7E);
        settle_cmp("R10 unknown functions");

        // R2 R11 random packets on random links
        for (int k = 0; k < 20; k++) begin
            int l, n, b;
            l = $urandom % 4; n = 1 + $urandom % 60;
            put(8'h40 | l); put(n); ex_rx(l, n);
            for (int i = 0; i < n; i++) begin b = $urandom % 256; put(b); ex_rx(l, b); end
            settle_cmp("R2 R11 random message");
        end

        // R1 R7 random prefixed dumps
        for (int k = 0; k < 5; k++) begin
            int off, cnt;
            off = $urandom % 600; cnt = $urandom % 200;
            put(8'h87); put_num(off); put_num(cnt); ex_dump(off, cnt);
            settle_cmp("R1 R7 random dump");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule